// File: doc/BRIEF.md
# Privileged Address Segment Decoder

This block sits between a 32-bit core's load/store path and its TLB. For every virtual address it decides which of five address windows the access falls into. It then checks that window against the current privilege level. Depending on the window, the address is either translated directly or handed to the TLB. All outcomes, including the TLB's answer, are folded into a single fault code.

The whole decode path is combinational. The only state is three fault-capture registers: a faulting-address copy, a page-table context word, and an entry-high word. They load on the clock edge where the fault strobe is high while a fault is being reported. This lets the exception logic snapshot them for the handler.

Top module: `vaddr_seg_decoder`

## Requirements
- R1: With `err_level` low, an address below 0x80000000 asserts `tlb_req` in every mode. A TLB hit (`tlb_resp` = 00) then gives `pa_ok` = 1, `pa` = `tlb_pa` and `fault_code` = 0.
- R2: With `err_level` high, an address below 0x80000000 bypasses the TLB (`tlb_req` = 0), gives `pa` = `va` with `pa_ok` = 1, and raises no fault in any mode.
- R3: In kernel mode (`mode` = 00), 0x80000000..0x9FFFFFFF is translated without the TLB to `va` − 0x80000000.
- R4: In kernel mode, 0xA0000000..0xBFFFFFFF is translated without the TLB to `va` − 0xA0000000.
- R5: 0xC0000000..0xDFFFFFFF goes to the TLB in kernel or supervisor (`mode` = 01) mode. In user mode (`mode` = 10) it is an address error.
- R6: 0xE0000000..0xFFFFFFFF goes to the TLB in kernel mode only. Supervisor and user accesses there are address errors.
- R7: A window the mode may not use gives `fault_code` 1 for a read and 2 for a write, with `tlb_req` = 0 and `pa_ok` = 0. Mode code 11 has user rights.
- R8: A TLB miss (`tlb_resp` = 01) on a mapped access gives `fault_code` 3 for a read or 4 for a write, with `refill` = 1.
- R9: A TLB invalid result (`tlb_resp` = 10) gives `fault_code` 3 for a read or 4 for a write, with `refill` = 0.
- R10: A TLB dirty result (`tlb_resp` = 11) gives `fault_code` 5 for both reads and writes, with `refill` = 0.
- R11: On a clock edge with `fault_strobe` high and a fault (`fault_code` ≠ 0), `badaddr_q` takes the full `va`.
- R12: On such an edge, `context_q` bits 22:4 take `va` bits 31:13, bits 31:23 are kept, and bits 3:0 are cleared.
- R13: On such an edge, `entryhi_q` bits 31:13 take `va` bits 31:13, bits 7:0 (the ASID) are kept, and bits 12:8 are cleared.
- R14: After reset the capture registers hold 0, `CTX_INIT` and `EHI_INIT`. On any edge without both strobe and fault, all three hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| va | input | 32 | Virtual address |
| is_write | input | 1 | 1 = store, 0 = load |
| mode | input | 2 | 00 kernel, 01 supervisor, 10/11 user |
| err_level | input | 1 | Error-level flag; low window becomes identity-mapped |
| tlb_resp | input | 2 | TLB result: 00 hit, 01 miss, 10 invalid, 11 dirty |
| tlb_pa | input | 32 | Physical address from the TLB on a hit |
| fault_strobe | input | 1 | Loads capture registers when a fault is reported |
| tlb_req | output | 1 | Access is permitted and mapped; TLB result is used |
| pa | output | 32 | Physical address |
| pa_ok | output | 1 | `pa` is a valid translation |
| fault_code | output | 3 | 0 none, 1/2 address error load/store, 3/4 TLB load/store, 5 modify |
| refill | output | 1 | Fault comes from a TLB miss |
| badaddr_q | output | 32 | Captured faulting address |
| context_q | output | 32 | Context word |
| entryhi_q | output | 32 | Entry-high word |

## Verification
The decode results (`tlb_req`, `pa`, `pa_ok`, `fault_code`, `refill`) are due in the same cycle as their inputs. The bench drives each input set on a falling edge and compares these outputs a short delay later, still before the next rising edge. The capture registers change one rising edge after a strobed fault. They are compared just after that edge, against a model that applies the capture rule on the same edge. The bench also checks cycles where the strobe has no fault, and where a fault has no strobe, so that holding is confirmed at the ports.

// File: rtl/vaddr_seg_decoder.sv
module vaddr_seg_decoder #(
  parameter logic [31:0] CTX_INIT = 32'h0,
  parameter logic [31:0] EHI_INIT = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] va,
  input  logic        is_write,
  input  logic [1:0]  mode,
  input  logic        err_level,
  input  logic [1:0]  tlb_resp,
  input  logic [31:0] tlb_pa,
  input  logic        fault_strobe,
  output logic        tlb_req,
  output logic [31:0] pa,
  output logic        pa_ok,
  output logic [2:0]  fault_code,
  output logic        refill,
  output logic [31:0] badaddr_q,
  output logic [31:0] context_q,
  output logic [31:0] entryhi_q
);
  localparam logic [2:0]  FC_NONE = 3'd0, FC_AEL = 3'd1, FC_AES = 3'd2,
                          FC_TL = 3'd3, FC_TS = 3'd4, FC_MOD = 3'd5;
  localparam logic [1:0]  RSP_HIT = 2'b00, RSP_MISS = 2'b01, RSP_INV = 2'b10;
  localparam logic [31:0] CTX_KEEP = 32'hFF80_0000;
  localparam logic [31:0] EHI_KEEP = 32'h0000_00FF;
  localparam logic [31:0] VPN_MASK = 32'hFFFF_E000;

  logic in_low, in_k0, in_k1, in_sup, in_k3;
  logic priv_k, priv_s, allowed, direct;

  assign in_low = ~va[31];
  assign in_k0  = va[31:29] == 3'b100;
  assign in_k1  = va[31:29] == 3'b101;
  assign in_sup = va[31:29] == 3'b110;
  assign in_k3  = va[31:29] == 3'b111;

  assign priv_k  = mode == 2'b00;
  assign priv_s  = mode == 2'b01;
  assign allowed = in_low | ((in_k0 | in_k1 | in_k3) & priv_k) | (in_sup & (priv_k | priv_s));
  assign direct  = (in_low & err_level) | in_k0 | in_k1;
  assign tlb_req = allowed & ~direct;

  always_comb begin
    if (in_low)
      pa = err_level ? va : tlb_pa;
    else if (in_k0 | in_k1)
      pa = {3'b000, va[28:0]};
    else
      pa = tlb_pa;
  end

  assign pa_ok = allowed & (direct | (tlb_resp == RSP_HIT));

  always_comb begin
    fault_code = FC_NONE;
    refill     = 1'b0;
    if (!allowed)
      fault_code = is_write ? FC_AES : FC_AEL;
    else if (tlb_req) begin
      case (tlb_resp)
        RSP_HIT:  fault_code = FC_NONE;
        RSP_MISS: begin fault_code = is_write ? FC_TS : FC_TL; refill = 1'b1; end
        RSP_INV:  fault_code = is_write ? FC_TS : FC_TL;
        default:  fault_code = FC_MOD;
      endcase
    end
  end

  logic capture;
  assign capture = fault_strobe & (fault_code != FC_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      badaddr_q <= '0;
      context_q <= CTX_INIT;
      entryhi_q <= EHI_INIT;
    end else if (capture) begin
      badaddr_q <= va;
      context_q <= (context_q & CTX_KEEP) | {9'b0, va[31:13], 4'b0};
      entryhi_q <= (entryhi_q & EHI_KEEP) | (va & VPN_MASK);
    end
  end

  // R3
  kseg0_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && va[31:29] == 3'b100) |-> (pa_ok && !tlb_req && pa == (va - 32'h8000_0000)));
  // R7
  user_kernel_ae_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && va[31]) |-> (!pa_ok && !tlb_req && fault_code == (is_write ? 3'd2 : 3'd1)));
  // R8
  refill_implies_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refill |-> (tlb_req && fault_code != 3'd0));
  // R11
  badaddr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_strobe && fault_code != 3'd0) |=> badaddr_q == $past(va));
  // R13
  asid_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(entryhi_q[7:0]));
  // R14
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault_strobe && fault_code != 3'd0) |=> ($stable(badaddr_q) && $stable(context_q) && $stable(entryhi_q)));
endmodule

// File: tb/test_vaddr_seg_decoder.sv
module test_vaddr_seg_decoder;
  localparam int CLK_P = 10;
  localparam logic [31:0] CTX0 = 32'hA5C0_000F;
  localparam logic [31:0] EHI0 = 32'h0000_1F3C;

  logic clk = 0, rst_n = 0;
  logic [31:0] va = 0, tlb_pa = 0;
  logic is_write = 0, err_level = 0, fault_strobe = 0;
  logic [1:0] mode = 0, tlb_resp = 0;
  logic tlb_req, pa_ok, refill;
  logic [31:0] pa, badaddr_q, context_q, entryhi_q;
  logic [2:0] fault_code;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_bad, m_ctx, m_ehi;
  logic e_req, e_ok, e_refill;
  logic [31:0] e_pa;
  int e_code;

  vaddr_seg_decoder #(.CTX_INIT(CTX0), .EHI_INIT(EHI0)) i_vaddr_seg_decoder (
    .clk(clk), .rst_n(rst_n), .va(va), .is_write(is_write), .mode(mode),
    .err_level(err_level), .tlb_resp(tlb_resp), .tlb_pa(tlb_pa),
    .fault_strobe(fault_strobe), .tlb_req(tlb_req), .pa(pa), .pa_ok(pa_ok),
    .fault_code(fault_code), .refill(refill), .badaddr_q(badaddr_q),
    .context_q(context_q), .entryhi_q(entryhi_q));

  always #(CLK_P/2) clk = ~clk;

  initial begin
    #(CLK_P*100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic void model();
    int lvl, need;
    bit mapped;
    lvl = (mode == 2'd0) ? 2 : (mode == 2'd1) ? 1 : 0;
    if (va < 32'h8000_0000) need = 0;
    else if (va >= 32'hC000_0000 && va < 32'hE000_0000) need = 1;
    else need = 2;
    e_req = 0; e_ok = 0; e_refill = 0; e_code = 0; e_pa = 'x;
    if (lvl < need) begin
      e_code = is_write ? 2 : 1;
      return;
    end
    mapped = 1;
    if (va < 32'h8000_0000 && err_level) begin mapped = 0; e_pa = va; end
    else if (va >= 32'h8000_0000 && va < 32'hA000_0000) begin mapped = 0; e_pa = va - 32'h8000_0000; end
    else if (va >= 32'hA000_0000 && va < 32'hC000_0000) begin mapped = 0; e_pa = va - 32'hA000_0000; end
    if (!mapped) begin e_ok = 1; return; end
    e_req = 1;
    case (tlb_resp)
      2'd0: begin e_ok = 1; e_pa = tlb_pa; end
      2'd1: begin e_code = is_write ? 4 : 3; e_refill = 1; end
      2'd2: e_code = is_write ? 4 : 3;
      default: e_code = 5;
    endcase
  endfunction

  task automatic step(string req, logic [31:0] a, logic w, logic [1:0] md, logic el,
                      logic [1:0] rsp, logic [31:0] tpa, logic stb);
    @(negedge clk);
    va = a; is_write = w; mode = md; err_level = el; tlb_resp = rsp; tlb_pa = tpa;
    fault_strobe = stb;
    #1;
    model();
    chk(req, "tlb_req", {31'b0, tlb_req}, {31'b0, e_req});
    chk(req, "pa_ok", {31'b0, pa_ok}, {31'b0, e_ok});
    chk(req, "fault_code", {29'b0, fault_code}, e_code[31:0]);
    chk(req, "refill", {31'b0, refill}, {31'b0, e_refill});
    if (e_ok) chk(req, "pa", pa, e_pa);
    @(posedge clk);
    if (stb && e_code != 0) begin
      m_bad = a;
      m_ctx = {m_ctx[31:23], a[31:13], 4'b0000};
      m_ehi = {a[31:13], 5'b00000, m_ehi[7:0]};
    end
    #1;
    chk(req, "badaddr_q", badaddr_q, m_bad);
    chk(req, "context_q", context_q, m_ctx);
    chk(req, "entryhi_q", entryhi_q, m_ehi);
  endtask

  initial begin
    m_bad = 0; m_ctx = CTX0; m_ehi = EHI0;
    repeat (3) @(posedge clk);
    #1;
    chk("R14", "reset badaddr_q", badaddr_q, 32'h0);
    chk("R14", "reset context_q", context_q, CTX0);
    chk("R14", "reset entryhi_q", entryhi_q, EHI0);
    rst_n = 1;

    for (int m = 0; m < 4; m++) begin
      step("R1", 32'h0040_1234, 0, m[1:0], 0, 2'd0, 32'h1F00_0234, 0);
      step("R2", 32'h7FFF_FFFC, 1, m[1:0], 1, 2'd1, 32'h0, 1);
    end
    step("R3", 32'h8000_0000, 0, 2'd0, 0, 2'd1, 32'h0, 1);
    step("R3", 32'h9FFF_FFFF, 1, 2'd0, 1, 2'd3, 32'h0, 1);
    step("R4", 32'hA000_0000, 0, 2'd0, 0, 2'd2, 32'h0, 0);
    step("R4", 32'hBFC0_0180, 1, 2'd0, 0, 2'd1, 32'h0, 1);
    step("R5", 32'hC000_4000, 0, 2'd0, 0, 2'd0, 32'h0ABC_D000, 0);
    step("R5", 32'hDFFF_F000, 1, 2'd1, 0, 2'd0, 32'h0123_4000, 0);
    step("R5", 32'hC123_4567, 0, 2'd2, 0, 2'd0, 32'h0, 1);
    step("R6", 32'hE000_0000, 0, 2'd0, 0, 2'd0, 32'h0765_4000, 0);
    step("R6", 32'hFFFF_FFF0, 1, 2'd1, 0, 2'd0, 32'h0, 1);
    step("R7", 32'h8765_4321, 0, 2'd1, 0, 2'd0, 32'h0, 1);
    step("R7", 32'hA000_1000, 1, 2'd2, 0, 2'd0, 32'h0, 1);
    step("R7", 32'hD000_2000, 1, 2'd3, 0, 2'd0, 32'h0, 1);
    step("R8", 32'h1234_5678, 0, 2'd2, 0, 2'd1, 32'h0, 1);
    step("R8", 32'hC765_8000, 1, 2'd1, 0, 2'd1, 32'h0, 1);
    step("R9", 32'h0000_2000, 0, 2'd0, 0, 2'd2, 32'h0, 1);
    step("R9", 32'hE00F_E000, 1, 2'd0, 0, 2'd2, 32'h0, 1);
    step("R10", 32'h4444_6000, 0, 2'd2, 0, 2'd3, 32'h0, 1);
    step("R10", 32'hF0F0_F0F0, 1, 2'd0, 0, 2'd3, 32'h0, 1);
    step("R11", 32'hFFFF_E001, 0, 2'd2, 0, 2'd0, 32'h0, 1);
    step("R12", 32'h0000_1FFF, 1, 2'd0, 0, 2'd1, 32'h0, 1);
    step("R13", 32'hDEAD_BEEF, 0, 2'd1, 0, 2'd3, 32'h0, 1);
    step("R14", 32'h9000_0000, 1, 2'd0, 0, 2'd1, 32'h0, 1);
    step("R14", 32'h8000_0040, 0, 2'd2, 0, 2'd0, 32'h0, 0);
    step("R14", 32'h0BAD_0000, 0, 2'd2, 0, 2'd1, 32'h0, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule